// File: doc/BRIEF.md
# Bus DMA Address Translator

This block sits between a bus device and system memory and turns every DMA address the device issues into a 50-bit system physical address. A request brings a 64-bit bus address and a flag that tells whether it arrived as a dual address cycle. The block decides from the top address bits which of three translations applies, and returns the translated address one cycle later. It also returns a mode code, an attribute field and a fault flag.

The three translations work as follows. A direct window joins a 17-bit base register above the low 31 address bits. A paged window looks up a small translation table, and the page size (4 KB or 16 KB) is chosen at runtime. A wide address passes straight through once its ten attribute bits are taken off. Software loads the base register, the page-size bit and the table entries through a one-cycle write port.

Top module: `dma_xlate`

## Requirements
- R1: After reset `rsp_valid` is 0. Every table entry is invalid, the base register is 0 and the page size is 4 KB.
- R2: Each cycle with `req_valid` high gives exactly one `rsp_valid` pulse on the next cycle, and `rsp_valid` is never high otherwise.
- R3: A request whose bits 63..32 are zero and whose bit 31 is set is direct. `rsp_paddr[30:0]` is address bits 30..0, `rsp_paddr[47:31]` is the 17-bit base register, bits 49..48 are 0, and `rsp_mode` is 2'b01.
- R4: A request whose bits 63..32 are zero, with bit 31 clear and bit 30 set, is paged (`rsp_mode` 2'b10). In 4 KB mode the entry index is bits 29..12 and `rsp_paddr` is {entry page number[37:0], address[11:0]}.
- R5: In 16 KB mode a paged request takes its index from bits 29..14, and `rsp_paddr` is {entry page number[35:0], address[13:0]}.
- R6: A paged request faults when its index is at or above the table depth (256) or when the selected entry is invalid.
- R7: A request with bits 63..54 all ones and `req_dac` high is wide (`rsp_mode` 2'b11). `rsp_paddr` is address bits 49..0 and `rsp_attr` is address bits 63..54.
- R8: A request whose bits 63..32 are zero is decoded as a 32-bit address whatever the value of `req_dac`.
- R9: A fault is raised in three cases: a 32-bit address with bits 31 and 30 both clear, a nonzero upper half whose bits 63..54 are not all ones, or a nonzero upper half without `req_dac`. A faulted response carries `rsp_fault`=1 with `rsp_paddr`, `rsp_mode` and `rsp_attr` all zero.
- R10: `rsp_attr` is zero for every response that is not wide.
- R11: A request in the same cycle as a configuration write is translated with the contents from before that write.
- R12: Configuration write encoding. With `cfg_tbl`=1, entry `cfg_addr` is loaded with valid = `cfg_wdata[38]` and page number = `cfg_wdata[37:0]`. With `cfg_tbl`=0 and `cfg_addr[0]`=0, the base register takes `cfg_wdata[16:0]`. With `cfg_tbl`=0 and `cfg_addr[0]`=1, the page size takes `cfg_wdata[0]` (1 = 16 KB).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 64 | Bus address of the request |
| req_dac | input | 1 | Request arrived as a dual address cycle |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_tbl | input | 1 | 1 selects a table entry, 0 selects a control register |
| cfg_addr | input | 8 | Entry index, or control register select in bit 0 |
| cfg_wdata | input | 39 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_paddr | output | 50 | Translated system address |
| rsp_mode | output | 2 | 00 fault, 01 direct, 10 paged, 11 wide |
| rsp_attr | output | 10 | Attribute bits of a wide request |
| rsp_fault | output | 1 | Translation fault |

## Verification
Direct requests are tried at both edges of the 31-bit window, with a zero base and with a programmed base, so the offset is kept apart from the base field. Paged requests are tried in both page sizes against the same entries, so the two index slices and the two offset widths are told apart. They are also tried at the last valid index, the first index past the table, and on invalid or invalidated entries. Wide requests are tried with and without the dual-cycle flag and with partial attribute patterns. Zero-upper requests under the dual-cycle flag, and requests that coincide with configuration writes, separate the 32-bit decode and the old-contents rule from their alternatives.

// File: rtl/dma_xlate.sv
module dma_xlate #(
  parameter int PA_W      = 50,
  parameter int TBL_DEPTH = 256,
  parameter int DMAP_W    = 17,
  parameter int ATTR_W    = 10,
  localparam int IDX_AW   = $clog2(TBL_DEPTH),
  localparam int PPN_W    = PA_W - 12,
  localparam int CFG_DW   = PPN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [63:0]       req_addr,
  input  logic              req_dac,
  input  logic              cfg_we,
  input  logic              cfg_tbl,
  input  logic [IDX_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [1:0]        rsp_mode,
  output logic [ATTR_W-1:0] rsp_attr,
  output logic              rsp_fault
);
  localparam logic [1:0] M_NONE = 2'b00, M_DIR = 2'b01, M_PAGE = 2'b10, M_WIDE = 2'b11;
  localparam int PAD_W = PA_W - 31 - DMAP_W;

  logic [DMAP_W-1:0] dmap;
  logic              page16;
  logic [PPN_W-1:0]  tbl_ppn [TBL_DEPTH];
  logic              tbl_vld [TBL_DEPTH];

  // configuration
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dmap   <= '0;
      page16 <= 1'b0;
      for (int i = 0; i < TBL_DEPTH; i++) begin
        tbl_vld[i] <= 1'b0;
        tbl_ppn[i] <= '0;
      end
    end else if (cfg_we) begin
      if (cfg_tbl) begin
        tbl_vld[cfg_addr] <= cfg_wdata[CFG_DW-1];
        tbl_ppn[cfg_addr] <= cfg_wdata[PPN_W-1:0];
      end else if (cfg_addr[0]) begin
        page16 <= cfg_wdata[0];
      end else begin
        dmap <= cfg_wdata[DMAP_W-1:0];
      end
    end
  end

  // decode
  wire upper_nz = |req_addr[63:32];
  wire attr_ok  = &req_addr[63:64-ATTR_W];
  wire is_wide  = upper_nz && attr_ok && req_dac;
  wire is_dir   = !upper_nz && req_addr[31];
  wire is_page  = !upper_nz && !req_addr[31] && req_addr[30];

  wire [17:0] idx      = page16 ? {2'b00, req_addr[29:14]} : req_addr[29:12];
  wire        in_range = idx < 18'(TBL_DEPTH);
  wire [IDX_AW-1:0] sel = in_range ? idx[IDX_AW-1:0] : '0;
  wire        hit      = in_range && tbl_vld[sel];
  wire [PPN_W-1:0] ppn = tbl_ppn[sel];

  logic [PA_W-1:0]   n_paddr;
  logic [1:0]        n_mode;
  logic [ATTR_W-1:0] n_attr;

  always_comb begin
    n_paddr = '0;
    n_mode  = M_NONE;
    n_attr  = '0;
    if (is_wide) begin
      n_paddr = req_addr[PA_W-1:0];
      n_mode  = M_WIDE;
      n_attr  = req_addr[63:64-ATTR_W];
    end else if (is_dir) begin
      n_paddr = {{PAD_W{1'b0}}, dmap, req_addr[30:0]};
      n_mode  = M_DIR;
    end else if (is_page && hit) begin
      n_paddr = page16 ? {ppn[PPN_W-3:0], req_addr[13:0]} : {ppn, req_addr[11:0]};
      n_mode  = M_PAGE;
    end
  end

  // response register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_mode  <= M_NONE;
      rsp_attr  <= '0;
      rsp_fault <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_paddr <= n_paddr;
        rsp_mode  <= n_mode;
        rsp_attr  <= n_attr;
        rsp_fault <= (n_mode == M_NONE);
      end
    end
  end
endmodule

module dma_xlate_chk #(
  parameter int PA_W   = 50,
  parameter int ATTR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [63:0]       req_addr,
  input logic              req_dac,
  input logic              rsp_valid,
  input logic [PA_W-1:0]   rsp_paddr,
  input logic [1:0]        rsp_mode,
  input logic [ATTR_W-1:0] rsp_attr,
  input logic              rsp_fault
);
  a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r3_direct_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[63:32] == 32'h0 && req_addr[31])
    |=> (rsp_mode == 2'b01 && !rsp_fault && rsp_paddr[30:0] == $past(req_addr[30:0])));
  a_r7_wide_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_dac && req_addr[63:54] == 10'h3FF)
    |=> (rsp_mode == 2'b11 && rsp_attr == $past(req_addr[63:54])
         && rsp_paddr == $past(req_addr[PA_W-1:0])));
  a_r9_no_dac_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_dac && req_addr[63:32] != 32'h0) |=> rsp_fault);
  a_r9_fault_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && rsp_mode == 2'b00 && rsp_attr == '0));
  a_r10_attr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_mode != 2'b11) |-> rsp_attr == '0);
endmodule

bind dma_xlate dma_xlate_chk #(.PA_W(PA_W), .ATTR_W(ATTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .req_dac(req_dac), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
  .rsp_mode(rsp_mode), .rsp_attr(rsp_attr), .rsp_fault(rsp_fault));

// File: tb/dma_xlate_bench.sv
module dma_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] req_addr = '0;
  logic        req_dac = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_tbl = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [38:0] cfg_wdata = '0;
  logic        rsp_valid;
  logic [49:0] rsp_paddr;
  logic [1:0]  rsp_mode;
  logic [9:0]  rsp_attr;
  logic        rsp_fault;

  dma_xlate u_dma_xlate (.*);

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_tag = "R1";

  // reference model state
  bit        m_vld [256];
  bit [37:0] m_ppn [256];
  bit [16:0] m_dmap;
  bit        m_p16;

  logic        e_valid;
  logic [49:0] e_paddr;
  logic [1:0]  e_mode;
  logic [9:0]  e_attr;
  logic        e_fault;
  string       e_tag;

  task automatic model(input bit [63:0] a, input bit d,
                       output bit [49:0] pa, output bit [1:0] md, output bit [9:0] at);
    longint unsigned full;
    int ix;
    pa = '0; md = 2'd0; at = '0;
    if (a[63:32] != 0) begin
      if (d && a[63:54] == 10'h3FF) begin
        md = 2'd3; at = a[63:54]; pa = a[49:0];
      end
    end else if (a[31]) begin
      md = 2'd1;
      full = (longint'(m_dmap) << 31) + longint'(a[30:0]);
      pa = full[49:0];
    end else if (a[30]) begin
      ix = m_p16 ? int'(a[29:14]) : int'(a[29:12]);
      if (ix < 256 && m_vld[ix]) begin
        md = 2'd2;
        if (m_p16) full = (longint'(m_ppn[ix]) << 14) + longint'(a[13:0]);
        else       full = (longint'(m_ppn[ix]) << 12) + longint'(a[11:0]);
        pa = full[49:0];
      end
    end
  endtask

  always @(posedge clk) begin
    bit [49:0] pa; bit [1:0] md; bit [9:0] at;
    cycles <= cycles + 1;
    if (!rst_n) begin
      e_valid <= 1'b0;
      m_dmap = '0; m_p16 = 1'b0;
      for (int i = 0; i < 256; i++) begin m_vld[i] = 1'b0; m_ppn[i] = '0; end
    end else begin
      e_valid <= req_valid;
      if (req_valid) begin
        model(req_addr, req_dac, pa, md, at);
        e_paddr <= pa; e_mode <= md; e_attr <= at; e_fault <= (md == 2'd0);
        e_tag <= cur_tag;
      end
      if (cfg_we) begin
        if (cfg_tbl) begin m_vld[cfg_addr] = cfg_wdata[38]; m_ppn[cfg_addr] = cfg_wdata[37:0]; end
        else if (cfg_addr[0]) m_p16 = cfg_wdata[0];
        else m_dmap = cfg_wdata[16:0];
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (rsp_valid !== e_valid) begin
        errors++;
        $display("FAIL R2 rsp_valid actual=%0b expected=%0b", rsp_valid, e_valid);
      end
      if (e_valid) begin
        checks++;
        if (rsp_fault !== e_fault || rsp_mode !== e_mode) begin
          errors++;
          $display("FAIL %s fault/mode actual=%0b/%0d expected=%0b/%0d", e_tag, rsp_fault, rsp_mode, e_fault, e_mode);
        end
        checks++;
        if (rsp_paddr !== e_paddr) begin
          errors++;
          $display("FAIL %s paddr actual=%h expected=%h", e_tag, rsp_paddr, e_paddr);
        end
        checks++;
        if (rsp_attr !== e_attr) begin
          errors++;
          $display("FAIL %s attr actual=%h expected=%h", e_tag, rsp_attr, e_attr);
        end
      end
    end
  end

  task automatic req(input logic [63:0] a, input logic d, input string tag);
    cur_tag = tag;
    req_valid = 1'b1; req_addr = a; req_dac = d;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic t, input logic [7:0] ad, input logic [38:0] dt);
    cfg_we = 1'b1; cfg_tbl = t; cfg_addr = ad; cfg_wdata = dt;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(2);
    // R1: reset contents
    req(64'h0000_0000_4000_0000, 1'b0, "R1");
    req(64'h0000_0000_8000_1234, 1'b0, "R1");
    idle(1);
    // R12 + R3: base register
    wr(1'b0, 8'd0, 39'h1_ABCD);
    req(64'h0000_0000_FFFF_FFFF, 1'b0, "R3");
    req(64'h0000_0000_8000_0000, 1'b0, "R3");
    req(64'h0000_0000_C000_0F00, 1'b0, "R3");
    // R12 + R4: 4 KB pages
    wr(1'b1, 8'd5,   {1'b1, 38'h23_4567_89AB});
    wr(1'b1, 8'd255, {1'b1, 38'h3F_FFFF_FFFF});
    wr(1'b1, 8'd0,   {1'b1, 38'h00_0000_0001});
    req(64'h0000_0000_4000_5ABC, 1'b0, "R4");
    req(64'h0000_0000_400F_F123, 1'b0, "R4");
    req(64'h0000_0000_4000_0FFF, 1'b1, "R4");
    // R6: out of range, invalid, invalidated
    req(64'h0000_0000_4010_0000, 1'b0, "R6");
    req(64'h0000_0000_4000_6000, 1'b0, "R6");
    wr(1'b1, 8'd0, {1'b0, 38'h0});
    req(64'h0000_0000_4000_0010, 1'b0, "R6");
    // R5: 16 KB pages
    wr(1'b0, 8'd1, 39'h1);
    req(64'h0000_0000_4001_7123, 1'b0, "R5");
    req(64'h0000_0000_403F_FFFF, 1'b0, "R5");
    req(64'h0000_0000_4040_0000, 1'b0, "R6");
    req(64'h0000_0000_4000_5ABC, 1'b0, "R6");
    // R7: wide
    req(64'hFFC0_0001_2345_6789, 1'b1, "R7");
    req(64'hFFFF_FFFF_FFFF_FFFF, 1'b1, "R7");
    req(64'hABFF_C000_0000_0001, 1'b1, "R9");
    req(64'hFFC0_0001_2345_6789, 1'b0, "R9");
    req(64'h7FC0_0000_0000_0000, 1'b1, "R9");
    req(64'h0000_0001_8000_0000, 1'b1, "R9");
    // R8: zero upper in dual cycle
    req(64'h0000_0000_8000_0010, 1'b1, "R8");
    req(64'h0000_0000_4000_5000, 1'b1, "R8");
    // R9: low bits clear
    req(64'h0000_0000_1234_5678, 1'b0, "R9");
    req(64'h0000_0000_0000_0000, 1'b1, "R9");
    // R10: attr zero after a wide response
    req(64'hFFC0_0000_0000_0000, 1'b1, "R7");
    req(64'h0000_0000_8765_4321, 1'b0, "R10");
    // R11: write and request together
    cur_tag = "R11";
    cfg_we = 1'b1; cfg_tbl = 1'b0; cfg_addr = 8'd0; cfg_wdata = 39'h0_5555;
    req_valid = 1'b1; req_addr = 64'h0000_0000_8000_0042; req_dac = 1'b0;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    req(64'h0000_0000_8000_0042, 1'b0, "R11");
    cur_tag = "R11";
    cfg_we = 1'b1; cfg_tbl = 1'b0; cfg_addr = 8'd1; cfg_wdata = 39'h0;
    req_valid = 1'b1; req_addr = 64'h0000_0000_4001_7000; req_dac = 1'b0;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    req(64'h0000_0000_4000_5000, 1'b0, "R11");
    // R2: idle gap then a burst
    idle(3);
    for (int k = 0; k < 6; k++) begin
      cur_tag = "R2";
      req_valid = 1'b1; req_addr = 64'h0000_0000_8000_0000 | 64'(k * 4096); req_dac = 1'b0;
      @(posedge clk); #1;
    end
    req_valid = 1'b0;
    idle(3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d cycles expected=below 20000", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule